// File: doc/BRIEF.md
# Serial Read Token Controller for Chained FIFOs

This block decides which of several chained parallel-to-serial FIFOs may read and drive a serial data line that they all share. The devices form a ring. Each device's token input is wired to the token output of the device before it, and every device sees the same serial clock, which arrives here as a one-cycle enable on the system clock. One device holds the read token at a time. While it holds the token it turns on its line driver and passes serial clock enables to its local shifter as read enables. When its shifter reports that the last bit of a word is going out, it pulses its token output and gives up the token. The next device in the ring takes the token on that same clock edge.

Two straps set the role of a device while reset is low. The first-load strap picks the device that holds the token when reset ends. The token input, when tied high by the board, selects single-device mode. In that mode the device always reads and always drives. Its token output then carries the local almost-empty/almost-full flag, because no ring is connected to it. Both straps are captured only while reset is active.

Top module: `tok_ring_ctl`

## Requirements
- R1: While `rst_n` is low, `tok_out`, `rd_en` and `so_oe` are all 0, whatever the other inputs do.
- R2: In chain mode, a device whose `first_load_n` equals `FIRST_OWNER_LEVEL` (default 0) during the last reset cycle holds the token when reset ends, and any other device does not. Changes on `first_load_n` after reset have no effect.
- R3: If `tok_in` is 1 during the last reset cycle, the device is in single-device mode. After reset, `so_oe` stays 1, `rd_en` equals `shift_en`, and `word_done` and `tok_in` have no effect.
- R4: In single-device mode, `tok_out` carries `almost_flag`. It lags by one clock when `FLAG_REG` is 1 (the default) and follows in the same cycle when `FLAG_REG` is 0.
- R5: In chain mode, a token holder has `so_oe` = 1 and `rd_en` equal to `shift_en`.
- R6: In chain mode, a device without the token has `so_oe` = 0 and `rd_en` = 0, even while `shift_en` is 1.
- R7: In chain mode, a token holder that sees `shift_en` and `word_done` both 1 in a cycle drives `tok_out` = 1 in that same cycle and no longer holds the token from the next cycle on.
- R8: In chain mode, a token holder keeps the token in any cycle where `shift_en` and `word_done` are not both 1.
- R9: In chain mode, a device without the token that sees `tok_in` = 1 holds the token from the next cycle on. A token holder ignores `tok_in`.
- R10: In chain mode, `tok_out` is 0 in every cycle other than a handoff cycle as defined in R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low; the straps are sampled while it is low |
| first_load_n | input | 1 | First-load strap; a value equal to FIRST_OWNER_LEVEL marks the initial token holder |
| tok_in | input | 1 | Token input from the previous device; tied high for single-device mode |
| shift_en | input | 1 | One-cycle enable for each serial clock edge, shared by all devices |
| word_done | input | 1 | From the local shifter: this shift moves out the last bit of the word |
| almost_flag | input | 1 | Local almost-empty/almost-full flag, sent on tok_out in single-device mode |
| tok_out | output | 1 | Handoff pulse to the next device, or the almost flag in single-device mode |
| rd_en | output | 1 | Read enable for the local shifter |
| so_oe | output | 1 | Output enable for the shared serial data line |

## Verification
Several rules are checked on every cycle by the bound checker. Outputs stay silent during reset. A read enable never occurs without the driver enabled. The holder's read enable follows the serial enable. A single device always drives. A chain device's token output fires only on a handoff, after which ownership drops, and it is regained one cycle after a token pulse. Other behaviour can only be shown by the bench's scenarios: which device holds the token from the strap value, that single-device mode is chosen from the token input during reset, that the strap is ignored after reset, and that the almost flag reaches the token output with its one-cycle lag. The bench sweeps every combination of the four dynamic inputs from both ownership states in chain mode and in single-device mode.

// File: rtl/tok_ring_pkg.sv
package tok_ring_pkg;
   typedef enum logic {
      MODE_CHAIN  = 1'b0,
      MODE_SINGLE = 1'b1
   } ring_mode_e;
endpackage

// File: rtl/tok_ring_strap.sv
// Captures the board straps while reset is low and holds them afterwards.
module tok_ring_strap #(
   parameter bit OWNER_LEVEL = 1'b0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    strap,
   input  logic                    tok_in,
   output logic                    first_now,
   output tok_ring_pkg::ring_mode_e mode
);
   import tok_ring_pkg::*;

   // Live strap decode: the ownership register loads it during reset.
   assign first_now = (strap == OWNER_LEVEL);

   // A chain predecessor keeps its token output low during reset, so a high
   // level seen here can only come from a board tie-off.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode <= tok_in ? MODE_SINGLE : MODE_CHAIN;
      end
   end
endmodule

// File: rtl/tok_ring_own.sv
// Token ownership register with same-cycle handoff detection.
module tok_ring_own (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     first_now,
   input  tok_ring_pkg::ring_mode_e mode,
   input  logic                     shift_en,
   input  logic                     word_done,
   input  logic                     tok_in,
   output logic                     owner,
   output logic                     handoff
);
   import tok_ring_pkg::*;

   logic own_q;
   logic chain;

   assign chain   = (mode == MODE_CHAIN);
   assign owner   = !chain || own_q;
   assign handoff = chain && own_q && shift_en && word_done;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         own_q <= first_now;
      end else if (chain) begin
         if (handoff) begin
            own_q <= 1'b0;
         end else if (!own_q && tok_in) begin
            own_q <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/tok_ring_out.sv
// Token-out pin: handoff pulse in a chain, almost flag on a single device.
module tok_ring_out #(
   parameter int unsigned FLAG_REG = 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  tok_ring_pkg::ring_mode_e mode,
   input  logic                     handoff,
   input  logic                     almost_flag,
   output logic                     tok_out
);
   import tok_ring_pkg::*;

   logic flag_sel;

   generate
      if (FLAG_REG != 0) begin : g_flag_reg
         logic flag_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               flag_q <= 1'b0;
            end else begin
               flag_q <= almost_flag;
            end
         end
         assign flag_sel = flag_q;
      end else begin : g_flag_comb
         logic unused_clk;
         assign unused_clk = clk;
         assign flag_sel   = almost_flag;
      end
   endgenerate

   assign tok_out = rst_n && ((mode == MODE_SINGLE) ? flag_sel : handoff);
endmodule

// File: rtl/tok_ring_ctl.sv
// Read-token controller for one device of a chain sharing a serial line.
module tok_ring_ctl #(
   parameter bit          FIRST_OWNER_LEVEL = 1'b0,
   parameter int unsigned FLAG_REG          = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic first_load_n,
   input  logic tok_in,
   input  logic shift_en,
   input  logic word_done,
   input  logic almost_flag,
   output logic tok_out,
   output logic rd_en,
   output logic so_oe
);
   import tok_ring_pkg::*;

   generate
      if (FLAG_REG > 1) begin : g_bad_flag_reg
         $error("tok_ring_ctl: FLAG_REG must be 0 or 1");
      end
   endgenerate

   ring_mode_e mode;
   logic       first_now;
   logic       owner;
   logic       handoff;
   logic       mode_is_single;

   tok_ring_strap #(.OWNER_LEVEL(FIRST_OWNER_LEVEL)) u_strap (
      .clk       (clk),
      .rst_n     (rst_n),
      .strap     (first_load_n),
      .tok_in    (tok_in),
      .first_now (first_now),
      .mode      (mode)
   );

   tok_ring_own u_own (
      .clk       (clk),
      .rst_n     (rst_n),
      .first_now (first_now),
      .mode      (mode),
      .shift_en  (shift_en),
      .word_done (word_done),
      .tok_in    (tok_in),
      .owner     (owner),
      .handoff   (handoff)
   );

   tok_ring_out #(.FLAG_REG(FLAG_REG)) u_out (
      .clk         (clk),
      .rst_n       (rst_n),
      .mode        (mode),
      .handoff     (handoff),
      .almost_flag (almost_flag),
      .tok_out     (tok_out)
   );

   assign mode_is_single = (mode == MODE_SINGLE);
   assign so_oe          = rst_n && owner;
   assign rd_en          = rst_n && owner && shift_en;
endmodule

// File: rtl/tok_ring_chk.sv
// Cycle-by-cycle protocol checks, bound to tok_ring_ctl.
module tok_ring_chk (
   input logic clk,
   input logic rst_n,
   input logic tok_in,
   input logic shift_en,
   input logic word_done,
   input logic tok_out,
   input logic rd_en,
   input logic so_oe,
   input logic single
);
   // R1: every output is silent while reset is held
   p_quiet_in_reset_r1: assert property (@(posedge clk)
      !rst_n |-> (!tok_out && !rd_en && !so_oe));

   // R3: a single device always drives the line
   p_single_drives_r3: assert property (@(posedge clk) disable iff (!rst_n)
      single |-> so_oe);

   // R5: the holder's read enable tracks the serial enable
   p_rd_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
      so_oe |-> (rd_en == shift_en));

   // R6: no read without owning the line
   p_rd_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |-> so_oe);

   // R7: a handoff pulse is followed by releasing the line
   p_handoff_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!single && tok_out) |=> !so_oe);

   // R8: the holder keeps the token unless a word finishes
   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!single && so_oe && !(shift_en && word_done)) |=> so_oe);

   // R9: a token pulse on an idle device makes it the holder
   p_take_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!single && !so_oe && tok_in) |=> so_oe);

   // R10: in a chain the token output fires only on a handoff
   p_tok_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!single && !(so_oe && shift_en && word_done)) |-> !tok_out);
endmodule

bind tok_ring_ctl tok_ring_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .tok_in    (tok_in),
   .shift_en  (shift_en),
   .word_done (word_done),
   .tok_out   (tok_out),
   .rd_en     (rd_en),
   .so_oe     (so_oe),
   .single    (mode_is_single)
);

// File: tb/tb_tok_ring_ctl.sv
`timescale 1ns/1ps
module tb_tok_ring_ctl;
   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic rst_n = 1'b0;
   logic first_load_n = 1'b1;
   logic tok_in = 1'b0;
   logic shift_en = 1'b0;
   logic word_done = 1'b0;
   logic almost_flag = 1'b0;
   logic tok_out, rd_en, so_oe;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   tok_ring_ctl dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .first_load_n (first_load_n),
      .tok_in       (tok_in),
      .shift_en     (shift_en),
      .word_done    (word_done),
      .almost_flag  (almost_flag),
      .tok_out      (tok_out),
      .rd_en        (rd_en),
      .so_oe        (so_oe)
   );

   task automatic chk(input string tag, input logic [2:0] act, input logic [2:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s {tok_out,rd_en,so_oe} actual=%b expected=%b", tag, act, exp);
      end
   endtask

   // Reset with given straps; returns at the negedge where reset is released.
   task automatic reset_to(input logic strap_v, input logic tin);
      @(negedge clk);
      rst_n = 1'b0;
      first_load_n = strap_v;
      tok_in = tin;
      shift_en = 1'b1;
      word_done = 1'b1;
      almost_flag = 1'b1;
      repeat (3) @(negedge clk);
      #1 chk("R1 outputs during reset", {tok_out, rd_en, so_oe}, 3'b000);
      @(negedge clk);
      rst_n = 1'b1;
      shift_en = 1'b0;
      word_done = 1'b0;
      almost_flag = 1'b0;
      first_load_n = ~strap_v;   // R2: strap changes after reset are ignored
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000) begin
         errors++;
         $display("FAIL watchdog actual=%0d cycles expected=finish", cycles);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      // Chain mode: every input combination from both ownership states.
      for (int o = 0; o < 2; o++) begin
         for (int c = 0; c < 16; c++) begin
            logic se, wd, ti, af, nxt;
            se = c[0]; wd = c[1]; ti = c[2]; af = c[3];
            reset_to(o ? 1'b0 : 1'b1, 1'b0);
            #1 chk("R2 initial holder from strap", {tok_out, rd_en, so_oe}, {2'b00, o[0]});
            shift_en = se; word_done = wd; tok_in = ti; almost_flag = af;
            #1 chk("R5/R6/R7/R10 chain outputs", {tok_out, rd_en, so_oe},
                   {o[0] & se & wd, o[0] & se, o[0]});
            nxt = o[0] ? !(se & wd) : ti;
            @(negedge clk);
            shift_en = 1'b0; word_done = 1'b0; tok_in = 1'b0; almost_flag = 1'b0;
            #1 chk("R7/R8/R9 ownership next cycle", {tok_out, rd_en, so_oe}, {2'b00, nxt});
            shift_en = 1'b1;
            #1 chk("R5/R6 read gating after step", {tok_out, rd_en, so_oe}, {1'b0, nxt, nxt});
            shift_en = 1'b0;
         end
      end

      // Single-device mode: token input tied high, both strap values.
      for (int c = 0; c < 16; c++) begin
         logic se, wd, af;
         se = c[0]; wd = c[1]; af = c[3];
         reset_to(c[2], 1'b1);
         #1 chk("R3 single mode after reset", {tok_out, rd_en, so_oe}, 3'b001);
         shift_en = se; word_done = wd; almost_flag = af;
         #1 chk("R3/R4 single outputs same cycle", {tok_out, rd_en, so_oe}, {1'b0, se, 1'b1});
         @(negedge clk);
         shift_en = 1'b0; word_done = 1'b0; almost_flag = 1'b0;
         #1 chk("R4 flag one cycle later", {tok_out, rd_en, so_oe}, {af, 1'b0, 1'b1});
         shift_en = 1'b1;
         #1 chk("R3 single keeps reading", {tok_out, rd_en, so_oe}, {af, 1'b1, 1'b1});
         shift_en = 1'b0;
      end

      // Chain pass-around: holder shifts bits, hands off, then regains.
      reset_to(1'b0, 1'b0);
      for (int b = 0; b < 3; b++) begin
         shift_en = 1'b1; word_done = (b == 2);
         @(negedge clk);
      end
      shift_en = 1'b0; word_done = 1'b0;
      #1 chk("R7 released after word", {tok_out, rd_en, so_oe}, 3'b000);
      tok_in = 1'b1;
      @(negedge clk);
      tok_in = 1'b0;
      #1 chk("R9 regained after token pulse", {tok_out, rd_en, so_oe}, 3'b001);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule